// File: doc/BRIEF.md
# Data-Strobe Serial Word Transmitter

This block turns a set of parallel converter samples into a fixed 44-bit serial word and sends it over two wires, a data line and a strobe line. Once per word period a capture pulse latches four 10-bit samples, two auxiliary audio bits and a slot-order mode into a holding register. A free-running bit counter reloads a shift register from that holding register every 44 bit-clock cycles, so words follow each other with no idle gap.

The strobe line changes whenever the data line does not. The exclusive-OR of the two lines therefore flips on every bit period, and a receiver can recover bit timing from that alone. A fixed two-bit marker closes every word, so the receiver finds the word boundary as the position where that marker repeats every 44 bits. No clock or frame wire travels with the link. The block runs in the bit-clock domain. The word-rate capture pulse is a one-cycle enable in that domain.

Top module: `ds_link_tx`

## Requirements
- R1: Each word is 44 bits long: four 10-bit sample slots, then two audio bits, then two marker bits. The marker bits are sent as 1 then 0 in the final two bit periods. Words are sent back to back with no idle bit between them.
- R2: Slot 0 is sent first and each sample goes most significant bit first. Audio bit 1 is sent before audio bit 0, directly after the last sample bit.
- R3: With `link_mode` = 0 at capture, slot i carries input lane i, where lane i is `samples[10*i+9:10*i]`.
- R4: With `link_mode` = 1 at capture, the slots carry lanes 0, 2, 1, 3 in that order.
- R5: Samples, audio bits and mode are taken only in a cycle with `word_stb` high. In every other cycle they have no effect on what is sent. If several capture pulses fall between two reloads, the last one is the word that is sent.
- R6: The bit counter starts at reset release. A reload happens at the 44th rising edge after reset release and at every 44th edge after that. Each reload takes the word captured at an edge strictly before it. The first bit of a word appears on `tx_data` after the edge that follows its reload.
- R7: If nothing is captured between two reloads, the previous word is sent again unchanged.
- R8: While transmitting, `tx_strobe` toggles exactly in the bit periods where `tx_data` keeps its previous value, so `tx_data ^ tx_strobe` flips on every bit. The first bit is compared against a previous state of both lines low.
- R9: After reset, `tx_data` and `tx_strobe` stay low until the first captured word starts to be sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, 44 times the word rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_stb | input | 1 | One-cycle capture pulse for the parallel word |
| samples | input | 40 | Four 10-bit sample lanes, lane i at bits 10*i+9 down to 10*i |
| aux | input | 2 | Two audio bits, bit 1 sent first |
| link_mode | input | 1 | Slot order: 0 lane order, 1 even lanes first |
| tx_data | output | 1 | Serial data line |
| tx_strobe | output | 1 | Serial strobe line |

## Verification
The bench drives changing values on the sample, audio and mode inputs in every cycle without a capture pulse. A design that latched its inputs at the wrong time would send that changing data. The bench places two capture pulses in one word period and expects the second word, and it places a capture on the reload edge itself. The latter must wait a full period: a design that reloaded from the incoming word in the same edge would send it 44 bits early. The bench skips a capture for one period and expects the old word to be resent, not zeros. It compares every bit period against a model of both lines. This catches an inverted strobe rule, a reversed marker or audio order, a wrong mode-1 slot order, and a one-bit gap or overlap at the reload.

// File: rtl/ds_link_tx.sv
module ds_link_tx #(
  parameter int SAMPLE_W = 10,
  parameter int NUM_SLOTS = 4,
  parameter int AUX_W = 2,
  parameter int SYNC_W = 2,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 2'b10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          word_stb,
  input  logic [NUM_SLOTS*SAMPLE_W-1:0] samples,
  input  logic [AUX_W-1:0]              aux,
  input  logic                          link_mode,
  output logic                          tx_data,
  output logic                          tx_strobe
);

  localparam int WORD_W = NUM_SLOTS*SAMPLE_W + AUX_W + SYNC_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int HALF   = NUM_SLOTS / 2;

  logic [WORD_W-1:0] asm_word, hold_q, shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              have_q, run_q, data_q, strb_q;
  logic              last_bit, next_bit;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam int ALT = (i < HALF) ? 2*i : 2*(i-HALF)+1;
    assign asm_word[WORD_W-1-i*SAMPLE_W -: SAMPLE_W] =
      link_mode ? samples[ALT*SAMPLE_W +: SAMPLE_W] : samples[i*SAMPLE_W +: SAMPLE_W];
  end
  assign asm_word[AUX_W+SYNC_W-1 -: AUX_W] = aux;
  assign asm_word[SYNC_W-1:0] = SYNC_PAT;

  assign last_bit = (cnt_q == CNT_W'(WORD_W-1));
  assign next_bit = shift_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      have_q <= 1'b0;
    end else begin
      cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
      if (word_stb) begin
        hold_q <= asm_word;
        have_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      run_q   <= 1'b0;
    end else if (last_bit && have_q) begin
      shift_q <= hold_q;
      run_q   <= 1'b1;
    end else begin
      shift_q <= {shift_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      strb_q <= 1'b0;
    end else if (run_q) begin
      data_q <= next_bit;
      strb_q <= (next_bit == data_q) ? ~strb_q : strb_q;
    end
  end

  assign tx_data   = data_q;
  assign tx_strobe = strb_q;

  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (!tx_data && !tx_strobe));

  a_r8_xor_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> ((tx_data ^ tx_strobe) != $past(tx_data ^ tx_strobe)));

  a_r1_marker_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && run_q) |-> (shift_q[SYNC_W-1:0] == SYNC_PAT));

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |=> $stable(hold_q));

  a_r6_counter_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W-1));

  a_r6_reload_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && run_q) |=> (cnt_q == '0));

endmodule

// File: tb/tb_ds_link_tx.sv
module tb_ds_link_tx;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, word_stb, link_mode;
  logic [39:0] samples;
  logic [1:0]  aux;
  wire         tx_data, tx_strobe;

  ds_link_tx dut (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .samples(samples),
    .aux(aux), .link_mode(link_mode), .tx_data(tx_data), .tx_strobe(tx_strobe)
  );

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] pat(input int p, input int i);
    if (p == 4) return 10'h000;
    if (p == 5) return 10'h3ff;
    if (p == 6) return (i % 2) ? 10'h155 : 10'h2aa;
    return 10'((p*97 + i*331 + p*p*13) & 1023);
  endfunction

  function automatic logic [43:0] build(input logic [39:0] s, input logic [1:0] a, input logic m);
    logic [9:0] l0, l1, l2, l3;
    l0 = s[9:0]; l1 = s[19:10]; l2 = s[29:20]; l3 = s[39:30];
    if (m) return {l0, l2, l1, l3, a[1], a[0], 2'b10};
    return {l0, l1, l2, l3, a[1], a[0], 2'b10};
  endfunction

  initial begin
    #(8*200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [43:0] mhold, mtx;
    bit mhave, mrun, fresh, pd, ps;
    int mload, first_edge;
    string mtag, htag;
    mhold = '0; mtx = '0; mhave = 0; mrun = 0; fresh = 0; pd = 0; ps = 0;
    mload = 0; first_edge = -1; mtag = "R3"; htag = "R3";
    rst_n = 0; word_stb = 0; samples = '0; aux = '0; link_mode = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(tx_data == 0 && tx_strobe == 0, "R9", {tx_data, tx_strobe}, 0);
    rst_n = 1;
    for (int k = 1; k <= 44*40; k++) begin
      int p, pp;
      bit stb, active, expd, exps;
      int idx;
      string tg, stag;
      logic [39:0] s;
      p = k / 44;
      stb = 0; pp = p; stag = "R3";
      if (k == 100) begin stb = 1; pp = 2; end
      else if (k >= 132 && (k % 44) == 10 && p != 7 && p != 11) stb = 1;
      else if (p == 9 && (k % 44) == 30) begin stb = 1; pp = 91; end
      else if (k == 44*11) begin stb = 1; pp = 111; end
      if (stb) begin
        for (int i = 0; i < 4; i++) s[10*i +: 10] = pat(pp, i);
        word_stb = 1; samples = s; aux = 2'(pp % 4); link_mode = ((pp / 2) % 2) == 1;
        stag = link_mode ? "R4" : "R3";
        if (p == 9) stag = "R5";
        if (k == 44*11) stag = "R6";
      end else begin
        word_stb = 0;
        samples = 40'(k * 32'h9e3779b1) ^ {k[7:0], 32'hc3a5_5a3c};
        aux = 2'(k); link_mode = (k % 2) == 1;
      end
      @(posedge clk);
      active = mrun;
      if (mrun) begin
        idx = k - mload - 1;
        expd = mtx[43-idx];
        exps = (expd == pd) ? ~ps : ps;
        tg = (idx >= 42) ? "R1" : (idx >= 40) ? "R2" : mtag;
      end else begin
        expd = 0; exps = 0; tg = "R9";
      end
      if ((k % 44) == 0 && mhave) begin
        mtx = mhold; mtag = fresh ? htag : "R7"; fresh = 0; mload = k; mrun = 1;
      end
      if (stb) begin
        mhold = build(samples, aux, link_mode); mhave = 1; htag = stag; fresh = 1;
      end
      @(negedge clk);
      chk(tx_data === expd, tg, tx_data, expd);
      chk(tx_strobe === exps, active ? "R8" : "R9", tx_strobe, exps);
      if (active) begin
        chk((tx_data ^ tx_strobe) != (pd ^ ps), "R8", tx_data ^ tx_strobe, !(pd ^ ps));
        if (first_edge < 0) begin
          first_edge = k;
          chk(k == 133, "R6", k, 133);
        end
      end
      pd = expd; ps = exps;
    end
    chk(first_edge == 133, "R6", first_edge, 133);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule